// File: doc/BRIEF.md
# Frame Sync Pulse Qualifier

This block takes an 8 kHz frame synchronization input in the transmit reference clock domain and decides which of its rising edges are genuine. It rejects any high pulse shorter than a minimum width. That minimum depends on the reference clock rate, on whether the sync source is timed synchronously or asynchronously to the clock, and on which of two input paths is selected. Each accepted rising edge realigns a free-running frame counter. Between edges, the counter keeps frame timing on its own as a flywheel.

A frame pulse is emitted once per frame period. Its high time equals one 77.76 MHz period: 2 clocks at the low rate and 8 clocks at the high rate. The block flags each rejected (runt) pulse for one cycle. It reports an in-sync status once the external sync agrees with the flywheel phase.

Top module: `fsq_qualifier`

## Requirements
- R1: While `rst_n` is low, `frame_pulse`, `runt_err` and `in_sync` are all 0.
- R2: `path_se`=1 selects `sync_se` and ignores `sync_diff`; `path_se`=0 selects `sync_diff` and ignores `sync_se`. The single-ended path always goes through a two-flop synchronizer, which delays the internal view of the input by 2 cycles. With `async_mode`=0 on the differential path, the delay is 0.
- R3: On the differential path with `async_mode`=0, a pulse qualifies when it stays high for at least 2 cycles (`rate_hi`=0) or at least 8 cycles (`rate_hi`=1).
- R4: When `async_mode`=1, or whenever the single-ended path is selected, the minimum high time is 3 cycles (`rate_hi`=0) or 9 cycles (`rate_hi`=1).
- R5: A pulse that falls before reaching the minimum width raises `runt_err` for exactly one cycle. That cycle is the one after the internal input is first seen low. The flywheel phase and `in_sync` are unchanged.
- R6: Suppose a qualified pulse is first seen high internally in cycle e. Then `frame_pulse` goes high in cycle e+N and again every N cycles with no further sync. N is FRAME_LO (default 19440) at `rate_hi`=0 and FRAME_HI (default 77760) at `rate_hi`=1.
- R7: Each frame pulse stays high for 2 cycles at `rate_hi`=0 and for 8 cycles at `rate_hi`=1.
- R8: `in_sync` becomes 1 in the cycle after the second of two qualified edges that lie exactly N cycles apart. A single qualified edge after reset leaves it at 0.
- R9: Suppose a qualified edge arrives while `in_sync`=1 and away from the flywheel wrap point. Then `in_sync` clears in the cycle after qualification, and that edge realigns the frame pulse to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_hi | input | 1 | 0: 155.52 MHz clock, 1: 622.08 MHz clock |
| async_mode | input | 1 | 1: differential sync is asynchronous to `clk` |
| path_se | input | 1 | 1: use single-ended sync input |
| sync_diff | input | 1 | Sync input from the differential receiver |
| sync_se | input | 1 | Single-ended sync input |
| frame_pulse | output | 1 | Flywheel frame pulse |
| runt_err | output | 1 | One-cycle flag for a rejected short pulse |
| in_sync | output | 1 | External sync agrees with flywheel phase |

## Verification
A wrong flywheel count or a wrong realignment value shows up as a frame pulse one or more cycles off its expected place. This appears no later than one frame period after the sync edge that should have set it. A wrong width count shows within a few cycles of the pulse's fall: a missing or extra `runt_err`, or a realignment where none belongs. A stale in-sync streak appears on `in_sync` one cycle after the second qualified edge. The bench shortens the frame lengths so that each of these effects falls within a short run.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  // Minimum qualifying high time; one extra cycle on the slow (synchronized) path.
  function automatic int unsigned fsq_min_width(input logic rate_hi, input logic slow_path,
                                                input int unsigned w_lo, input int unsigned w_hi);
    int unsigned w;
    w = rate_hi ? w_hi : w_lo;
    return slow_path ? w + 1 : w;
  endfunction

  // Rate-dependent pick used for frame length and frame pulse width.
  function automatic int unsigned fsq_pick(input logic rate_hi,
                                           input int unsigned v_lo, input int unsigned v_hi);
    return rate_hi ? v_hi : v_lo;
  endfunction

endpackage

// File: rtl/fsq_input_stage.sv
module fsq_input_stage #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic path_se,
  input  logic async_mode,
  input  logic sync_diff,
  input  logic sync_se,
  output logic slow_path,
  output logic sync_int
);
  logic raw;
  logic [SYNC_STAGES-1:0] chain;

  assign raw       = path_se ? sync_se : sync_diff;
  assign slow_path = path_se | async_mode;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_int = slow_path ? chain[SYNC_STAGES-1] : raw;
endmodule

// File: rtl/fsq_width_qual.sv
module fsq_width_qual #(
  parameter int unsigned HC_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sync_int,
  input  logic [HC_W-1:0] min_w,
  output logic            qual,
  output logic            runt_fall,
  output logic            runt_err
);
  logic [HC_W-1:0] hi_cnt;
  logic [HC_W-1:0] hi_inc;

  assign hi_inc    = hi_cnt + HC_W'(1);
  // Qualification fires once, in the cycle the high run reaches min_w.
  assign qual      = sync_int && (hi_inc == min_w);
  assign runt_fall = !sync_int && (hi_cnt != '0) && (hi_cnt < min_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      runt_err <= 1'b0;
    end else begin
      if (!sync_int)           hi_cnt <= '0;
      else if (hi_cnt != '1)   hi_cnt <= hi_inc;
      runt_err <= runt_fall;
    end
  end
endmodule

// File: rtl/fsq_flywheel.sv
module fsq_flywheel #(
  parameter int unsigned CNT_W = 17,
  parameter int unsigned HC_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qual,
  input  logic [HC_W-1:0]  min_w,
  input  logic [CNT_W-1:0] frame_len,
  input  logic [CNT_W-1:0] pulse_len,
  output logic [CNT_W-1:0] cnt,
  output logic             on_time,
  output logic             frame_pulse,
  output logic             in_sync
);
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] qual_pos;
  logic             seen_edge;

  // At qualification the edge lies min_w-1 cycles back, so the aligned phase is min_w-1.
  assign qual_pos = CNT_W'(min_w) - CNT_W'(1);
  assign on_time  = (cnt == qual_pos);

  always_comb begin
    if (qual)                              cnt_nxt = CNT_W'(min_w);
    else if (cnt >= frame_len - CNT_W'(1)) cnt_nxt = '0;
    else                                   cnt_nxt = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      frame_pulse <= 1'b0;
      in_sync     <= 1'b0;
      seen_edge   <= 1'b0;
    end else begin
      cnt         <= cnt_nxt;
      frame_pulse <= (cnt_nxt < pulse_len);
      if (qual) begin
        seen_edge <= 1'b1;
        in_sync   <= on_time && seen_edge;
      end
    end
  end
endmodule

// File: rtl/fsq_qualifier.sv
module fsq_qualifier #(
  parameter int unsigned FRAME_LO = 19440,
  parameter int unsigned FRAME_HI = 77760,
  parameter int unsigned MINW_LO  = 2,
  parameter int unsigned MINW_HI  = 8,
  parameter int unsigned FPW_LO   = 2,
  parameter int unsigned FPW_HI   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_hi,
  input  logic async_mode,
  input  logic path_se,
  input  logic sync_diff,
  input  logic sync_se,
  output logic frame_pulse,
  output logic runt_err,
  output logic in_sync
);
  import fsq_pkg::*;

  localparam int unsigned FRAME_MAX = (FRAME_HI > FRAME_LO) ? FRAME_HI : FRAME_LO;
  localparam int unsigned CNT_W     = $clog2(FRAME_MAX + 1);
  localparam int unsigned HC_W      = $clog2(MINW_HI + 2) + 1;

  logic             slow_path;
  logic             sync_int;
  logic             qual;
  logic             runt_fall;
  logic             on_time;
  logic [HC_W-1:0]  min_w;
  logic [CNT_W-1:0] frame_len;
  logic [CNT_W-1:0] pulse_len;
  logic [CNT_W-1:0] cnt;

  assign min_w     = HC_W'(fsq_min_width(rate_hi, slow_path, MINW_LO, MINW_HI));
  assign frame_len = CNT_W'(fsq_pick(rate_hi, FRAME_LO, FRAME_HI));
  assign pulse_len = CNT_W'(fsq_pick(rate_hi, FPW_LO, FPW_HI));

  fsq_input_stage #(.SYNC_STAGES(2)) u_in (
    .clk(clk), .rst_n(rst_n), .path_se(path_se), .async_mode(async_mode),
    .sync_diff(sync_diff), .sync_se(sync_se), .slow_path(slow_path), .sync_int(sync_int)
  );

  fsq_width_qual #(.HC_W(HC_W)) u_wq (
    .clk(clk), .rst_n(rst_n), .sync_int(sync_int), .min_w(min_w),
    .qual(qual), .runt_fall(runt_fall), .runt_err(runt_err)
  );

  fsq_flywheel #(.CNT_W(CNT_W), .HC_W(HC_W)) u_fw (
    .clk(clk), .rst_n(rst_n), .qual(qual), .min_w(min_w),
    .frame_len(frame_len), .pulse_len(pulse_len), .cnt(cnt), .on_time(on_time),
    .frame_pulse(frame_pulse), .in_sync(in_sync)
  );
endmodule

// File: rtl/fsq_checker.sv
module fsq_checker #(
  parameter int unsigned CNT_W     = 17,
  parameter int unsigned FPW_HI    = 8,
  parameter int unsigned FRAME_MAX = 77760
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_pulse,
  input logic             runt_err,
  input logic             in_sync,
  input logic             qual,
  input logic             on_time,
  input logic [CNT_W-1:0] cnt
);
  logic [7:0] fp_run;

  always_ff @(posedge clk) begin
    if (!rst_n)           fp_run <= '0;
    else if (!frame_pulse) fp_run <= '0;
    else if (fp_run != 8'hFF) fp_run <= fp_run + 8'd1;
  end

  AST_RUNT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    runt_err |=> !runt_err);                                  // R5
  AST_QUAL_REALIGNS: assert property (@(posedge clk) disable iff (!rst_n)
    qual |=> !frame_pulse);                                   // R6
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(FRAME_MAX));                                 // R6
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    fp_run <= 8'(FPW_HI));                                    // R7
  AST_SYNC_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync) |-> $past(qual && on_time));               // R8
  AST_SYNC_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_sync) |-> $past(qual && !on_time));              // R9
endmodule

bind fsq_qualifier fsq_checker #(
  .CNT_W(CNT_W), .FPW_HI(FPW_HI), .FRAME_MAX(FRAME_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .runt_err(runt_err),
  .in_sync(in_sync), .qual(qual), .on_time(on_time), .cnt(cnt)
);

// File: tb/fsq_qualifier_tb.sv
module fsq_qualifier_tb;
  localparam int NLO = 40;
  localparam int NHI = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rate_hi = 1'b0, async_mode = 1'b0, path_se = 1'b0;
  logic sync_diff = 1'b0, sync_se = 1'b0;
  logic frame_pulse, runt_err, in_sync;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  typedef struct { int t; int sig; bit val; string tag; } exp_t;
  exp_t sb[$];

  fsq_qualifier #(.FRAME_LO(NLO), .FRAME_HI(NHI)) u_dut (
    .clk(clk), .rst_n(rst_n), .rate_hi(rate_hi), .async_mode(async_mode),
    .path_se(path_se), .sync_diff(sync_diff), .sync_se(sync_se),
    .frame_pulse(frame_pulse), .runt_err(runt_err), .in_sync(in_sync)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic expect_at(input int t, input int sig, input bit v, input string tag);
    exp_t e;
    e.t = t; e.sig = sig; e.val = v; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: samples 2 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].t == cyc) begin
          logic a;
          a = (sb[i].sig == 0) ? frame_pulse : (sb[i].sig == 1) ? runt_err : in_sync;
          chk(a == sb[i].val, sb[i].tag, int'(a), int'(sb[i].val));
          sb.delete(i);
        end
      end
    end
  end

  task automatic wait_to(input int t);
    do @(negedge clk); while (cyc < t);
  endtask

  // Drive a high pulse of w cycles starting at the current negedge.
  task automatic pulse(input bit on_se, input int w);
    if (on_se) sync_se = 1'b1; else sync_diff = 1'b1;
    repeat (w) @(negedge clk);
    if (on_se) sync_se = 1'b0; else sync_diff = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s, a, b, c, d, g, h, i, j, k;
    repeat (4) @(negedge clk);
    chk(frame_pulse == 1'b0, "R1 frame_pulse in reset", frame_pulse, 0);
    chk(runt_err == 1'b0, "R1 runt_err in reset", runt_err, 0);
    chk(in_sync == 1'b0, "R1 in_sync in reset", in_sync, 0);
    rst_n = 1'b1;

    // Low rate, differential, synchronous: min width 2, no latency.
    wait_to(20); s = cyc;
    expect_at(s+39, 0, 0, "R6 no pulse before period");
    expect_at(s+40, 0, 1, "R6 pulse at e+N");
    expect_at(s+41, 0, 1, "R7 pulse second cycle");
    expect_at(s+42, 0, 0, "R7 pulse ends after 2");
    expect_at(s+5,  2, 0, "R8 one edge not enough");
    pulse(0, 2);
    wait_to(s+40);
    expect_at(s+42, 2, 1, "R8 in_sync after second edge");
    expect_at(s+120, 0, 1, "R6 flywheel keeps period");
    expect_at(s+122, 0, 0, "R7 flywheel pulse width");
    pulse(0, 2);

    // Runt on sync differential path.
    wait_to(s+130);
    expect_at(s+132, 1, 1, "R5 runt flagged");
    expect_at(s+133, 1, 0, "R5 runt one cycle");
    expect_at(s+135, 2, 1, "R5 runt keeps in_sync");
    expect_at(s+160, 0, 1, "R5 runt does not realign");
    pulse(0, 1);

    // Off-phase qualified edge.
    wait_to(s+170);
    expect_at(s+172, 2, 0, "R9 in_sync clears");
    expect_at(s+200, 0, 0, "R9 old phase gone");
    expect_at(s+210, 0, 1, "R9 realigned pulse");
    pulse(0, 3);

    // Asynchronous differential: min width 3, latency 2.
    wait_to(s+215); async_mode = 1'b1;
    wait_to(s+220); a = cyc;
    expect_at(a+5, 1, 1, "R4 async width 2 is runt");
    expect_at(s+250, 0, 1, "R5 async runt keeps phase");
    pulse(0, 2);
    wait_to(s+260); b = cyc;
    expect_at(b+41, 0, 0, "R2 async latency no early pulse");
    expect_at(b+42, 0, 1, "R2 async latency 2 pulse");
    pulse(0, 3);

    // Single-ended path, async_mode low.
    wait_to(s+310); async_mode = 1'b0; path_se = 1'b1;
    wait_to(s+320); c = cyc;
    expect_at(b+82, 0, 1, "R2 diff input ignored on se path");
    expect_at(c+3, 1, 0, "R2 diff input no runt on se path");
    pulse(0, 1);
    wait_to(s+350); d = cyc;
    expect_at(d+5, 1, 1, "R4 se width 2 is runt");
    pulse(1, 2);
    wait_to(s+360); g = cyc;
    expect_at(g+41, 0, 0, "R2 se no early pulse");
    expect_at(g+42, 0, 1, "R2 se realigned pulse");
    expect_at(b+122, 0, 0, "R2 se old phase gone");
    pulse(1, 3);

    // High rate, differential, synchronous: min width 8, pulse width 8.
    wait_to(s+410); path_se = 1'b0; rate_hi = 1'b1;
    wait_to(s+420); h = cyc;
    expect_at(h+8, 1, 1, "R3 hi width 7 is runt");
    expect_at(h+9, 1, 0, "R5 hi runt one cycle");
    pulse(0, 7);
    wait_to(h+20); i = cyc;
    expect_at(i+99,  0, 0, "R3 hi no early pulse");
    expect_at(i+100, 0, 1, "R3 hi width 8 qualifies");
    expect_at(i+107, 0, 1, "R7 hi pulse eighth cycle");
    expect_at(i+108, 0, 0, "R7 hi pulse ends after 8");
    pulse(0, 8);

    // High rate asynchronous: min width 9.
    wait_to(i+110); async_mode = 1'b1;
    wait_to(i+120); j = cyc;
    expect_at(j+11, 1, 1, "R4 hi async width 8 is runt");
    pulse(0, 8);
    wait_to(j+30); k = cyc;
    expect_at(k+101, 0, 0, "R4 hi async no early pulse");
    expect_at(k+102, 0, 1, "R4 hi async width 9 qualifies");
    pulse(0, 9);

    wait_to(k+115);
    chk(sb.size() == 0, "R6 scoreboard drained", sb.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule